// File: doc/BRIEF.md
# Program Counter with Latched Upper Bits

This block holds the instruction address of a small microcontroller core. The address is 13 bits wide. Software can read and write only the low byte. The five upper bits have no direct access path. Whenever the core loads a new address, the upper bits are filled from a separate 5-bit holding register, which software writes on its own port.

Each load source fills the address in its own way. A write to the low byte takes the 8-bit ALU result as the low bits. It copies the whole holding register into the upper five bits. A jump or call takes an 11-bit literal from the opcode. Only the top two bits of the holding register go above that literal. A return load takes a full 13-bit address from the return stack. An interrupt takes a fixed vector address. With none of these requested, the address counts up by one per enabled cycle.

The load strobes are decoded by a control module into a one-hot selection. A datapath module holds the address register and its next-value multiplexer. A third module holds the upper-bit register.

Top module: `pc_unit`

## Requirements
- R1: While reset is asserted (rstN low), pc reads 0x0000 and the holding register is cleared to 0. After reset is released, pc stays 0x0000 until a request arrives.
- R2: With incEn as the only request, pc advances by one at each clock edge. The value 0x1FFF wraps to 0x0000.
- R3: With lowWrEn as the highest request, pc becomes {holding[4:0], lowWrData} at the next edge. The holding value used is the one stored before that edge, even if latchWrEn is asserted in the same cycle.
- R4: With jumpEn as the highest request, pc becomes {holding[4:3], jumpLit[10:0]} at the next edge.
- R5: A low-byte write never carries into the upper bits. For example, a write of 0x00 while pc[7:0] is 0xFF leaves pc[12:8] equal to the holding register, not the old upper bits plus one.
- R6: With retEn as the highest request, pc becomes retAddr at the next edge.
- R7: With vecEn asserted, pc becomes the parameter VEC_ADDR (default 0x0004) at the next edge.
- R8: When several requests are asserted together, the order of precedence is vecEn, then retEn, then jumpEn, then lowWrEn, then incEn.
- R9: The holding register changes only at an edge where latchWrEn is high, and then takes latchWrData. No pc load or return load alters it.
- R10: With no request asserted, pc holds its value. The lowByte output always equals pc[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Sequential increment request |
| lowWrEn | input | 1 | Write strobe for the low byte |
| lowWrData | input | 8 | ALU result written to the low byte |
| jumpEn | input | 1 | Jump or call request |
| jumpLit | input | 11 | Opcode literal used as the jump target |
| retEn | input | 1 | Return address load request |
| retAddr | input | 13 | Return address from the stack |
| vecEn | input | 1 | Interrupt vector load request |
| latchWrEn | input | 1 | Write strobe for the upper-bit holding register |
| latchWrData | input | 5 | Data written to the holding register |
| pc | output | 13 | Current program counter |
| lowByte | output | 8 | Readable low byte of the program counter |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, an 8-bit low byte, an 11-bit jump literal and a vector at 0x0004. At these sizes a full wrap from 0x1FFF can be reached by one return load followed by a single increment. The holding register is small enough that random writes cover every upper-bit pattern. The random stimulus keeps each strobe sparse, so that every source wins the priority often. Directed cases then force all strobes together, a low-byte rollover, and a holding-register write in the same cycle as a low-byte write.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // One-hot selection of the next program counter source.
  typedef struct packed {
    logic selVec;
    logic selRet;
    logic selJump;
    logic selLow;
    logic selInc;
  } pcSel_t;

  localparam pcSel_t SEL_HOLD = '{selVec: 1'b0, selRet: 1'b0, selJump: 1'b0,
                                  selLow: 1'b0, selInc: 1'b0};

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic   vecEn,
  input  logic   retEn,
  input  logic   jumpEn,
  input  logic   lowWrEn,
  input  logic   incEn,
  output pcSel_t sel
);

  // Fixed precedence: vector, return, jump, low write, increment.
  always_comb begin
    sel = SEL_HOLD;
    if (vecEn)        sel.selVec  = 1'b1;
    else if (retEn)   sel.selRet  = 1'b1;
    else if (jumpEn)  sel.selJump = 1'b1;
    else if (lowWrEn) sel.selLow  = 1'b1;
    else if (incEn)   sel.selInc  = 1'b1;
  end

endmodule

// File: rtl/pc_hilatch.sv
module pc_hilatch #(
  parameter int LATCH_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LATCH_W-1:0] wrData,
  output logic [LATCH_W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     q <= '0;
    else if (wrEn) q <= wrData;
  end

endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int              PC_W     = 13,
  parameter int              LOW_W    = 8,
  parameter int              LIT_W    = 11,
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004,
  localparam int             HI_W     = PC_W - LOW_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcSel_t           sel,
  input  logic [HI_W-1:0]  latchQ,
  input  logic [LOW_W-1:0] lowWrData,
  input  logic [LIT_W-1:0] jumpLit,
  input  logic [PC_W-1:0]  retAddr,
  output logic [PC_W-1:0]  pcQ
);

  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] jumpTarget;
  logic [PC_W-1:0] lowTarget;

  // The upper bits come only from the holding register; no carry from the ALU.
  assign lowTarget = {latchQ, lowWrData};

  // Jump target: the literal, topped up from the upper holding bits if narrower.
  generate
    if (LIT_W >= PC_W) begin : g_fullLit
      assign jumpTarget = jumpLit[PC_W-1:0];
    end else begin : g_splitLit
      localparam int JHI_W = PC_W - LIT_W;
      assign jumpTarget = {latchQ[HI_W-1 -: JHI_W], jumpLit};
    end
  endgenerate

  always_comb begin
    unique case (1'b1)
      sel.selVec:  pcNext = VEC_ADDR;
      sel.selRet:  pcNext = retAddr;
      sel.selJump: pcNext = jumpTarget;
      sel.selLow:  pcNext = lowTarget;
      sel.selInc:  pcNext = pcQ + PC_W'(1);
      default:     pcNext = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int              PC_W     = 13,
  parameter int              LOW_W    = 8,
  parameter int              LIT_W    = 11,
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004,
  localparam int             HI_W     = PC_W - LOW_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic             lowWrEn,
  input  logic [LOW_W-1:0] lowWrData,
  input  logic             jumpEn,
  input  logic [LIT_W-1:0] jumpLit,
  input  logic             retEn,
  input  logic [PC_W-1:0]  retAddr,
  input  logic             vecEn,
  input  logic             latchWrEn,
  input  logic [HI_W-1:0]  latchWrData,
  output logic [PC_W-1:0]  pc,
  output logic [LOW_W-1:0] lowByte
);

  pcSel_t          sel;
  logic [HI_W-1:0] latchQ;

  pc_ctrl i_ctrl (
    .vecEn   (vecEn),
    .retEn   (retEn),
    .jumpEn  (jumpEn),
    .lowWrEn (lowWrEn),
    .incEn   (incEn),
    .sel     (sel)
  );

  pc_hilatch #(.LATCH_W(HI_W)) i_latch (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (latchWrEn),
    .wrData (latchWrData),
    .q      (latchQ)
  );

  pc_datapath #(
    .PC_W(PC_W), .LOW_W(LOW_W), .LIT_W(LIT_W), .VEC_ADDR(VEC_ADDR)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sel       (sel),
    .latchQ    (latchQ),
    .lowWrData (lowWrData),
    .jumpLit   (jumpLit),
    .retAddr   (retAddr),
    .pcQ       (pc)
  );

  assign lowByte = pc[LOW_W-1:0];

endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int              PC_W     = 13,
  parameter int              LOW_W    = 8,
  parameter int              LIT_W    = 11,
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004,
  localparam int             HI_W     = PC_W - LOW_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             incEn,
  input logic             lowWrEn,
  input logic [LOW_W-1:0] lowWrData,
  input logic             jumpEn,
  input logic             retEn,
  input logic [PC_W-1:0]  retAddr,
  input logic             vecEn,
  input logic             latchWrEn,
  input logic [HI_W-1:0]  latchWrData,
  input logic [HI_W-1:0]  latchQ,
  input logic [PC_W-1:0]  pc,
  input logic [LOW_W-1:0] lowByte
);

  logic anyReq;
  assign anyReq = incEn | lowWrEn | jumpEn | retEn | vecEn;

  assert_vector_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    vecEn |=> pc == VEC_ADDR);

  assert_return_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retEn && !vecEn) |=> pc == $past(retAddr));

  assert_low_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lowWrEn && !jumpEn && !retEn && !vecEn)
      |=> pc == {$past(latchQ), $past(lowWrData)});

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !lowWrEn && !jumpEn && !retEn && !vecEn)
      |=> pc == $past(pc) + PC_W'(1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> $stable(pc));

  assert_latch_only_by_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !latchWrEn |=> $stable(latchQ));

  assert_latch_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    latchWrEn |=> latchQ == $past(latchWrData));

  always_comb begin
    if (rstN) begin
      assert_low_byte_R10: assert (lowByte == pc[LOW_W-1:0]);
    end
  end

endmodule

bind pc_unit pc_unit_chk #(
  .PC_W(PC_W), .LOW_W(LOW_W), .LIT_W(LIT_W), .VEC_ADDR(VEC_ADDR)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .incEn       (incEn),
  .lowWrEn     (lowWrEn),
  .lowWrData   (lowWrData),
  .jumpEn      (jumpEn),
  .retEn       (retEn),
  .retAddr     (retAddr),
  .vecEn       (vecEn),
  .latchWrEn   (latchWrEn),
  .latchWrData (latchWrData),
  .latchQ      (latchQ),
  .pc          (pc),
  .lowByte     (lowByte)
);

// File: tb/test_pc_unit.sv
`timescale 1ns/1ps
module test_pc_unit;

  localparam int          PC_W  = 13;
  localparam int          LOW_W = 8;
  localparam int          LIT_W = 11;
  localparam int          HI_W  = PC_W - LOW_W;
  localparam logic [12:0] VEC   = 13'h0004;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             incEn = 1'b0, lowWrEn = 1'b0, jumpEn = 1'b0;
  logic             retEn = 1'b0, vecEn = 1'b0, latchWrEn = 1'b0;
  logic [LOW_W-1:0] lowWrData = '0;
  logic [LIT_W-1:0] jumpLit = '0;
  logic [PC_W-1:0]  retAddr = '0;
  logic [HI_W-1:0]  latchWrData = '0;
  logic [PC_W-1:0]  pc;
  logic [LOW_W-1:0] lowByte;

  int nChecks = 0;
  int nFails  = 0;
  logic [PC_W-1:0] expPc = '0;
  logic [HI_W-1:0] expLatch = '0;
  string curTag = "R1";

  always #4 clk = ~clk;

  pc_unit i_pc_unit (
    .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrEn(lowWrEn),
    .lowWrData(lowWrData), .jumpEn(jumpEn), .jumpLit(jumpLit),
    .retEn(retEn), .retAddr(retAddr), .vecEn(vecEn),
    .latchWrEn(latchWrEn), .latchWrData(latchWrData),
    .pc(pc), .lowByte(lowByte)
  );

  // Model of the next counter value from the requirements.
  function automatic logic [PC_W-1:0] modelNext(logic [PC_W-1:0] cur,
                                                logic [HI_W-1:0] lat);
    if (vecEn)        return VEC;                           // R7, R8
    else if (retEn)   return retAddr;                       // R6
    else if (jumpEn)  return {lat[4:3], jumpLit};           // R4
    else if (lowWrEn) return {lat, lowWrData};              // R3, R5
    else if (incEn)   return cur + 13'd1;                   // R2
    else              return cur;                           // R10
  endfunction

  function automatic string modelTag();
    if (vecEn && (retEn || jumpEn || lowWrEn || incEn)) return "R8";
    else if (vecEn)   return "R7";
    else if (retEn)   return "R6";
    else if (jumpEn)  return "R4";
    else if (lowWrEn) return "R3";
    else if (incEn)   return "R2";
    else              return "R10";
  endfunction

  task automatic check(string tag, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: pc actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Called at a falling edge with the inputs set: steps the model and checks
  // the outputs at the next falling edge.
  task automatic stepAndCheck();
    string tag;
    tag = modelTag();
    expPc = modelNext(expPc, expLatch);
    if (latchWrEn) expLatch = latchWrData;                  // R9
    @(negedge clk);
    check(tag, pc, expPc);
    check("R10", {5'd0, lowByte}, {5'd0, pc[7:0]});
  endtask

  task automatic idle();
    incEn = 0; lowWrEn = 0; jumpEn = 0; retEn = 0; vecEn = 0; latchWrEn = 0;
  endtask

  initial begin
    #1600000;
    nFails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", pc, 13'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", pc, 13'h0000);
    // R1: holding register cleared, seen through a low write
    idle(); lowWrEn = 1; lowWrData = 8'h5A;
    stepAndCheck();
    check("R1", {8'd0, pc[12:8]}, 13'd0);

    // R2: wrap from 0x1FFF
    idle(); retEn = 1; retAddr = 13'h1FFF; stepAndCheck();
    idle(); incEn = 1; stepAndCheck();
    check("R2", pc, 13'h0000);

    // R5: low byte at 0xFF, holding 0x03, write 0x00 -> no carry
    idle(); latchWrEn = 1; latchWrData = 5'h03; stepAndCheck();
    idle(); lowWrEn = 1; lowWrData = 8'hFF; stepAndCheck();
    idle(); lowWrEn = 1; lowWrData = 8'h00; stepAndCheck();
    check("R5", pc, 13'h0300);

    // R3: latch write in the same cycle uses the old holding value
    idle(); lowWrEn = 1; lowWrData = 8'h77; latchWrEn = 1; latchWrData = 5'h1C;
    stepAndCheck();
    check("R3", pc, 13'h0377);
    idle(); lowWrEn = 1; lowWrData = 8'h11; stepAndCheck();
    check("R3", pc, 13'h1C11);

    // R4: jump picks holding[4:3] = 2'b11
    idle(); jumpEn = 1; jumpLit = 11'h2A5; stepAndCheck();
    check("R4", pc, 13'h1AA5);

    // R9: loads do not touch the holding register
    idle(); retEn = 1; retAddr = 13'h0ABC; stepAndCheck();
    idle(); vecEn = 1; stepAndCheck();
    idle(); lowWrEn = 1; lowWrData = 8'h42; stepAndCheck();
    check("R9", pc, 13'h1C42);

    // R8: everything at once -> vector; then ret over jump
    idle(); vecEn = 1; retEn = 1; jumpEn = 1; lowWrEn = 1; incEn = 1;
    stepAndCheck();
    check("R8", pc, VEC);
    idle(); retEn = 1; retAddr = 13'h1234; jumpEn = 1; lowWrEn = 1; incEn = 1;
    stepAndCheck();
    check("R8", pc, 13'h1234);

    // R10: hold
    idle(); stepAndCheck(); stepAndCheck();
    check("R10", pc, 13'h1234);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      vecEn       = ($urandom_range(0, 15) == 0);
      retEn       = ($urandom_range(0, 9) == 0);
      jumpEn      = ($urandom_range(0, 7) == 0);
      lowWrEn     = ($urandom_range(0, 5) == 0);
      incEn       = ($urandom_range(0, 3) != 0);
      latchWrEn   = ($urandom_range(0, 5) == 0);
      lowWrData   = LOW_W'($urandom);
      jumpLit     = LIT_W'($urandom);
      retAddr     = PC_W'($urandom);
      latchWrData = HI_W'($urandom);
      stepAndCheck();
    end

    // Mid-run reset returns to zero (R1)
    idle();
    rstN = 1'b0;
    @(negedge clk);
    check("R1", pc, 13'h0000);
    rstN = 1'b1;
    expPc = '0; expLatch = '0;
    lowWrEn = 1; lowWrData = 8'h01; stepAndCheck();
    check("R1", pc, 13'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule